// File: doc/BRIEF.md
# Two-Port SRAM March Self-Test Engine

This engine tests a small asynchronous memory that has one port only for reads and one port only for writes. The memory holds 72 words of 8 bits. The engine runs a 13N march: every address sees thirteen operations, spread over five passes. The first pass writes the all-zeros background in ascending order. Two ascending passes follow, then two descending passes. Each of these four passes reads the current background, writes its complement, and reads the complement back.

The memory answers with zero latency. Each read word is therefore compared against the expected background in the same clock cycle the read is issued. Any mismatch raises a sticky fail flag.

A single `start` pulse, taken while the engine is idle, begins a run. `busy` is high for the whole run. `done` pulses for one cycle at the end, and then the engine returns to idle. The engine runs on the rising edge of a test clock and is cleared by a synchronous reset. While it is not running, all three active-low memory enables are held high.

Top module: `sram_march_bist`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), `busy`, `done` and `fail` are 0 and `wrEnN`, `rdEnN`, `outEnN` are 1.
- R2: Whenever `busy` is 0, `wrEnN`, `rdEnN` and `outEnN` are all 1.
- R3: A run issues 936 operations, one per cycle, in this order:
  - Pass 0 writes 8'h00 to addresses 0..71, ascending.
  - Passes 1 and 2 run ascending over 0..71.
  - Passes 3 and 4 run descending over 71..0.
  - At each address of passes 1 to 4, the engine reads background B, writes ~B, then reads ~B.
  - B is 8'h00 for passes 1 and 3, and 8'hFF for passes 2 and 4.
- R4: No address above 71 ever appears on `wrAddr` while `wrEnN` is 0, nor on `rdAddr` while `rdEnN` is 0.
- R5: A write cycle has `wrEnN`=0 and `rdEnN`=`outEnN`=1. A read cycle has `rdEnN`=`outEnN`=0 and `wrEnN`=1. Read and write are never enabled together.
- R6: `start` sampled high in idle makes `busy` high from the next cycle for exactly 936 cycles. `done` is then 1 for exactly one cycle with `busy` 0, after which the engine is idle.
- R7: A read whose `rdData` differs from the expected background in the cycle of the read sets `fail`. It is visible in the `done` cycle at the latest.
- R8: `fail` stays set through idle cycles until reset or until the next accepted `start`, which clears it.
- R9: `start` while `busy` is high has no effect on the running sequence or its length.
- R10: Against a fault-free memory, `fail` is 0 at the end of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| rdData | input | 8 | Memory read data (zero latency) |
| wrAddr | output | 7 | Memory write address |
| wrData | output | 8 | Memory write data |
| wrEnN | output | 1 | Write enable, active low |
| rdAddr | output | 7 | Memory read address |
| rdEnN | output | 1 | Read enable, active low |
| outEnN | output | 1 | Output enable, active low |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench follows every cycle of each run against an expected operation stream computed from the march definition. A counter that wrapped at 127 would show addresses past 71, and a descending pass that started at the wrong end would show a wrong address on its first operation. Stuck bits are injected at the boundary addresses 0 and 71 and at random cells. A compare taken one cycle late, or a wrong background, would leave `fail` low or raise it against clean memory. A `start` pulse in the middle of a run shows whether the sequence restarts. Further checks confirm that `fail` survives idle cycles and is cleared by a new start and by reset.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} bistState_t;

  typedef struct packed {
    logic clearFail;
    logic loadLow;
    logic loadHigh;
    logic stepUp;
    logic stepDown;
    logic doWrite;
    logic doRead;
    logic dataOnes;
  } bistStrobe_t;

  localparam logic [2:0] LAST_PASS  = 3'd4;
  localparam logic [2:0] FIRST_DESC = 3'd3;
endpackage

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_bist_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        atLow,
  input  logic        atHigh,
  output bistStrobe_t strb,
  output logic        busy,
  output logic        done
);
  bistState_t state, nextState;
  logic [2:0] pass, nextPass;
  logic [1:0] opIdx, nextOp;
  logic descNow, lastOp, isWrite, firstOnes, opOnes, atEnd;

  always_comb begin
    descNow   = (pass >= FIRST_DESC);
    lastOp    = (pass == 3'd0) || (opIdx == 2'd2);
    isWrite   = (pass == 3'd0) || (opIdx == 2'd1);
    firstOnes = (pass == 3'd2) || (pass == 3'd4);
    if (pass == 3'd0) opOnes = 1'b0;
    else if (opIdx == 2'd0) opOnes = firstOnes;
    else opOnes = ~firstOnes;
    atEnd = descNow ? atLow : atHigh;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    nextPass  = pass;
    nextOp    = opIdx;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clearFail = 1'b1;
          strb.loadLow   = 1'b1;
          nextState      = ST_RUN;
          nextPass       = 3'd0;
          nextOp         = 2'd0;
        end
      end
      ST_RUN: begin
        strb.doWrite  = isWrite;
        strb.doRead   = ~isWrite;
        strb.dataOnes = opOnes;
        if (!lastOp) begin
          nextOp = opIdx + 2'd1;
        end else begin
          nextOp = 2'd0;
          if (!atEnd) begin
            strb.stepUp   = ~descNow;
            strb.stepDown = descNow;
          end else if (pass == LAST_PASS) begin
            nextState = ST_FIN;
          end else begin
            nextPass = pass + 3'd1;
            if (3'(pass + 3'd1) >= FIRST_DESC) strb.loadHigh = 1'b1;
            else strb.loadLow = 1'b1;
          end
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pass  <= 3'd0;
      opIdx <= 2'd0;
    end else begin
      state <= nextState;
      pass  <= nextPass;
      opIdx <= nextOp;
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/march_dpath.sv
module march_dpath
  import march_bist_pkg::*;
#(
  parameter int unsigned DEPTH = 72,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  bistStrobe_t   strb,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic          wrEnN,
  output logic [AW-1:0] rdAddr,
  output logic          rdEnN,
  output logic          outEnN,
  output logic          atLow,
  output logic          atHigh,
  output logic          fail
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] addr;
  logic [DW-1:0] background;

  assign background = {DW{strb.dataOnes}};
  assign atLow      = (addr == '0);
  assign atHigh     = (addr == TOP_ADDR);

  assign wrAddr = addr;
  assign rdAddr = addr;
  assign wrData = background;
  assign wrEnN  = ~strb.doWrite;
  assign rdEnN  = ~strb.doRead;
  assign outEnN = ~strb.doRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (strb.loadLow) begin
      addr <= '0;
    end else if (strb.loadHigh) begin
      addr <= TOP_ADDR;
    end else if (strb.stepUp) begin
      addr <= addr + AW'(1);
    end else if (strb.stepDown) begin
      addr <= addr - AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearFail) begin
      fail <= 1'b0;
    end else if (strb.doRead && (rdData != background)) begin
      fail <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_march_bist.sv
module sram_march_bist
  import march_bist_pkg::*;
#(
  parameter int unsigned DEPTH = 72,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic          wrEnN,
  output logic [AW-1:0] rdAddr,
  output logic          rdEnN,
  output logic          outEnN,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  bistStrobe_t strb;
  logic atLow, atHigh;

  march_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .atLow  (atLow),
    .atHigh (atHigh),
    .strb   (strb),
    .busy   (busy),
    .done   (done)
  );

  march_dpath #(.DEPTH(DEPTH), .DW(DW)) i_dpath (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .rdData (rdData),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrEnN  (wrEnN),
    .rdAddr (rdAddr),
    .rdEnN  (rdEnN),
    .outEnN (outEnN),
    .atLow  (atLow),
    .atHigh (atHigh),
    .fail   (fail)
  );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int unsigned DEPTH = 72,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] wrAddr,
  input logic          wrEnN,
  input logic [AW-1:0] rdAddr,
  input logic          rdEnN,
  input logic          outEnN,
  input logic          busy,
  input logic          done,
  input logic          fail
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  // R5
  port_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!wrEnN && !rdEnN));

  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEnN |-> (wrAddr <= TOP_ADDR));

  // R4
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEnN |-> (rdAddr <= TOP_ADDR));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (wrEnN && rdEnN && outEnN));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !busy && !done)) |=> fail);
endmodule

bind sram_march_bist march_bist_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .wrAddr (wrAddr),
  .wrEnN  (wrEnN),
  .rdAddr (rdAddr),
  .rdEnN  (rdEnN),
  .outEnN (outEnN),
  .busy   (busy),
  .done   (done),
  .fail   (fail)
);

// File: tb/bist_mem_model.sv
module bist_mem_model #(
  parameter int unsigned DEPTH = 72,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          wrEnN,
  input  logic [AW-1:0] rdAddr,
  input  logic          rdEnN,
  input  logic          outEnN,
  input  logic          faultOn,
  input  logic [AW-1:0] faultAddr,
  input  logic [DW-1:0] sa0Mask,
  input  logic [DW-1:0] sa1Mask,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] raw;

  always_ff @(posedge clk) begin
    if (!wrEnN && (int'(wrAddr) < DEPTH)) cells[wrAddr] <= wrData;
  end

  always_comb begin
    raw = (int'(rdAddr) < DEPTH) ? cells[rdAddr] : '0;
    if (faultOn && (rdAddr == faultAddr)) raw = (raw & ~sa0Mask) | sa1Mask;
    rdData = (!rdEnN && !outEnN) ? raw : '0;
  end
endmodule

// File: tb/test_sram_march_bist.sv
`timescale 1ns/1ps
module test_sram_march_bist;
  localparam int DEPTH = 72;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int NOPS  = 13 * DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DW-1:0] rdData, wrData;
  logic [AW-1:0] wrAddr, rdAddr;
  logic wrEnN, rdEnN, outEnN, busy, done, fail;
  logic faultOn = 1'b0;
  logic [AW-1:0] faultAddr = '0;
  logic [DW-1:0] sa0Mask = '0;
  logic [DW-1:0] sa1Mask = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_march_bist #(.DEPTH(DEPTH), .DW(DW)) i_sram_march_bist (
    .clk(clk), .rst(rst), .start(start), .rdData(rdData),
    .wrAddr(wrAddr), .wrData(wrData), .wrEnN(wrEnN),
    .rdAddr(rdAddr), .rdEnN(rdEnN), .outEnN(outEnN),
    .busy(busy), .done(done), .fail(fail)
  );

  bist_mem_model #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .clk(clk), .wrAddr(wrAddr), .wrData(wrData), .wrEnN(wrEnN),
    .rdAddr(rdAddr), .rdEnN(rdEnN), .outEnN(outEnN),
    .faultOn(faultOn), .faultAddr(faultAddr), .sa0Mask(sa0Mask),
    .sa1Mask(sa1Mask), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected operation k of a run: write flag, address, data byte
  function automatic void expOp(input int k, output bit isW, output int a,
                                output int d);
    int j, p, r, pos, o;
    bit first;
    if (k < DEPTH) begin
      isW = 1'b1; a = k; d = 0;
    end else begin
      j = k - DEPTH;
      p = 1 + j / (3 * DEPTH);
      r = j % (3 * DEPTH);
      pos = r / 3;
      o = r % 3;
      a = (p <= 2) ? pos : (DEPTH - 1 - pos);
      first = (p == 2) || (p == 4);
      isW = (o == 1);
      d = ((o == 0) ? first : !first) ? 255 : 0;
    end
  endfunction

  function automatic bit quiet();
    return wrEnN && rdEnN && outEnN;
  endfunction

  task automatic runMarch(input bit expFail, input int pulseAt);
    bit isW, ok;
    int a, d;
    @(negedge clk) start = 1'b1;
    for (int k = 0; k < NOPS; k++) begin
      @(negedge clk);
      start = (k == pulseAt);
      expOp(k, isW, a, d);
      if (isW)
        ok = !wrEnN && rdEnN && outEnN && (int'(wrAddr) == a) && (int'(wrData) == d);
      else
        ok = !rdEnN && !outEnN && wrEnN && (int'(rdAddr) == a);
      ok = ok && busy && !done;
      // R3 R4 R5 R9: every operation in order, one per cycle
      chk(ok, "R3", $sformatf("op %0d addr", k), isW ? int'(wrAddr) : int'(rdAddr), a);
    end
    start = 1'b0;
    @(negedge clk);
    // R6: done one cycle after the last operation
    chk(done && !busy, "R6", "done pulse", int'(done), 1);
    // R7 R10: verdict
    chk(fail == expFail, expFail ? "R7" : "R10", "fail at done", int'(fail), int'(expFail));
    @(negedge clk);
    // R2 R6: back to idle, enables inactive
    chk(!done && !busy && quiet(), "R2", "idle after done", int'({done, busy, wrEnN, rdEnN, outEnN}), 7);
  endtask

  task automatic setFault(input bit on, input int a, input int b, input bit pol);
    faultOn   = on;
    faultAddr = AW'(a);
    sa0Mask   = pol ? '0 : DW'(1 << b);
    sa1Mask   = pol ? DW'(1 << b) : '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20467));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fail, "R1", "status after reset", int'({busy, done, fail}), 0);
    chk(quiet(), "R1", "enables after reset", int'({wrEnN, rdEnN, outEnN}), 7);

    // clean run
    runMarch(1'b0, -1);

    // R9: start pulse in mid-run ignored
    runMarch(1'b0, 400);

    // R7: stuck-at-1 at lowest address
    setFault(1'b1, 0, 0, 1'b1);
    runMarch(1'b1, -1);
    // R8: fail survives idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(fail, "R8", "fail held while idle", int'(fail), 1);
    end

    // R8: new start clears fail
    setFault(1'b0, 0, 0, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!fail, "R8", "fail cleared by start", int'(fail), 0);
    while (busy) @(negedge clk);
    chk(done && !fail, "R10", "clean rerun", int'(fail), 0);
    repeat (2) @(negedge clk);

    // R7: stuck-at-0 at highest address
    setFault(1'b1, DEPTH - 1, DW - 1, 1'b0);
    runMarch(1'b1, -1);

    // R1 R8: reset clears fail
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(!fail && !busy && !done, "R1", "fail cleared by reset", int'(fail), 0);

    // random faults, last one fault-free
    for (int i = 0; i < 6; i++) begin
      setFault(i != 5, $urandom_range(DEPTH - 1, 0), $urandom_range(DW - 1, 0),
               1'($urandom_range(1, 0)));
      runMarch(i != 5, (i == 2) ? int'($urandom_range(NOPS - 2, 1)) : -1);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule